// File: doc/BRIEF.md
# Inline ECC fetch injector

This block sits on the request path between an initiator and a DRAM controller. Requests arrive already split into bank, row and column fields. The block first remaps each request so that the top columns of every physical row stay free for ECC storage. It then decides whether the ECC word that covers the target region has been fetched recently. If it has not, the block sends a 32-byte ECC read downstream before it forwards the request. That read targets the reserved column region of the same bank and row.

Each bank keeps a short history of the (ECC block, row) pairs it has seen. A pair found in the history lets the request pass with no extra traffic. On the response side, the block consumes the responses to its own ECC reads and does the handshake for them itself. All other responses pass straight through to the initiator.

The remap needs a division by the data-column count. A small sequential divider does this work. The upstream ready stays low from acceptance until the remapped request has gone downstream, so only one request is in flight at a time.

Top module: `ecc_fetch_injector`

## Requirements
- R1: After reset, inReady is 1, outValid is 0 and upRespValid is 0. Every bank's history is empty, so the first request to any bank causes an ECC read.
- R2: For a request (row, col), let idx = row*256 + col. The forwarded data request carries column idx mod 1792 and row (row + floor(idx/1792)) modulo 2^ROW_W. It carries the same bank and write flag, with outEcc = 0 and a column below 1792.
- R3: A request whose (remapped column >> 9, remapped row) pair is in its bank's history is forwarded as a single data request, and no ECC read precedes it.
- R4: On a miss, the first downstream request has outEcc = 1 and outWrite = 0. It goes to the same bank and remapped row, at column 1792 + (remapped column >> 9)*32.
- R5: Once an ECC read is accepted (outValid and outReady both 1), the next downstream request is the held original request, and the block accepts no new upstream request before it.
- R6: Each bank keeps its last 3 missed pairs. A miss pushes the new pair in and drops the oldest one. A hit changes nothing. Banks are independent.
- R7: inReady is 0 from the cycle after an upstream acceptance until the data request has been accepted downstream. inReady and outValid are never 1 together. While outValid is 1 and outReady is 0, all output fields hold.
- R8: A downstream response with dsRespEcc = 1 is absorbed, with dsRespReady = 1 and upRespValid = 0. One with dsRespEcc = 0 is shown as upRespValid, and dsRespReady follows upRespReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Upstream request valid |
| inReady | output | 1 | Upstream request ready |
| inBank | input | BANK_W | Request bank |
| inRow | input | ROW_W | Request row (logical) |
| inCol | input | COL_W | Request column (logical) |
| inWrite | input | 1 | Request is a write |
| outValid | output | 1 | Downstream request valid |
| outReady | input | 1 | Downstream request ready |
| outBank | output | BANK_W | Downstream bank |
| outRow | output | ROW_W | Downstream remapped row |
| outCol | output | COL_W | Downstream column (data or ECC region) |
| outWrite | output | 1 | Downstream write flag (0 for ECC reads) |
| outEcc | output | 1 | Marks an internally generated ECC read |
| dsRespValid | input | 1 | Response valid from the controller |
| dsRespEcc | input | 1 | Response belongs to an internal ECC read |
| dsRespReady | output | 1 | Response ready toward the controller |
| upRespValid | output | 1 | Response valid toward the initiator |
| upRespReady | input | 1 | Initiator accepts the response |

## Verification
A corrupted history entry shows up at the very next request to the affected bank and row region. Either an ECC read appears where only a data request was expected, or one is missing, and the first downstream handshake of that request reveals it. A divider fault shows as a wrong row or column on the data request. Sweeping row and column values across the 1792 and 512 boundaries exposes it at once. A control-state fault shows within one handshake as a wrong order of tagged and untagged requests, or as inReady rising too early.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef struct packed {
    logic load;      // capture request, start remap division
    logic histPush;  // record the (block,row) pair of the held request
    logic selEcc;    // output mux selects the ECC read address
  } injStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIVIDE, ST_DECIDE, ST_SEND_ECC, ST_SEND_DATA
  } injState_t;
endpackage

// File: rtl/ecc_inj_datapath.sv
module ecc_inj_datapath
  import ecc_inj_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 11,
  parameter int LOG_SHIFT  = 8,
  parameter int DATA_COLS  = 1792,
  parameter int BLOCK_COLS = 512,
  parameter int ECC_STEP   = 32,
  parameter int HIST_DEPTH = 3,
  localparam int BANK_W    = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  injStrobes_t       st,
  input  logic [BANK_W-1:0] inBank,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic              inWrite,
  output logic              divDone,
  output logic              hit,
  output logic [BANK_W-1:0] outBank,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic              outWrite
);
  localparam int IDX_W  = ((ROW_W + LOG_SHIFT) > COL_W ? (ROW_W + LOG_SHIFT) : COL_W) + 1;
  localparam int REM_W  = $clog2(DATA_COLS) + 1;
  localparam int CNT_W  = $clog2(IDX_W + 1);
  localparam int BLK_SH = $clog2(BLOCK_COLS);
  localparam int BLK_W  = COL_W - BLK_SH;

  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic              reqWrite;
  logic [IDX_W-1:0]  idxShift, quo;
  logic [REM_W-1:0]  rem, trial;
  logic [CNT_W-1:0]  cnt;
  logic              busy, ge;

  assign trial = {rem[REM_W-2:0], idxShift[IDX_W-1]};
  assign ge    = trial >= REM_W'(DATA_COLS);

  // restoring divider by the constant data-column count, one quotient bit per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBank <= '0; reqRow <= '0; reqWrite <= 1'b0;
      idxShift <= '0; quo <= '0; rem <= '0; cnt <= '0; busy <= 1'b0;
    end else if (st.load) begin
      reqBank  <= inBank;
      reqRow   <= inRow;
      reqWrite <= inWrite;
      idxShift <= (IDX_W'(inRow) << LOG_SHIFT) + IDX_W'(inCol);
      quo      <= '0;
      rem      <= '0;
      cnt      <= CNT_W'(IDX_W);
      busy     <= 1'b1;
    end else if (busy) begin
      rem      <= ge ? trial - REM_W'(DATA_COLS) : trial;
      quo      <= {quo[IDX_W-2:0], ge};
      idxShift <= idxShift << 1;
      cnt      <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign divDone = !busy;

  logic [ROW_W-1:0] newRow;
  logic [COL_W-1:0] newCol, eccCol;
  logic [BLK_W-1:0] blk;

  assign newRow = reqRow + ROW_W'(quo);
  assign newCol = COL_W'(rem);
  assign blk    = newCol[COL_W-1:BLK_SH];
  assign eccCol = COL_W'(DATA_COLS) + COL_W'(blk) * COL_W'(ECC_STEP);

  // per-bank shift-register history of (block,row) pairs
  logic [BANKS-1:0] bankHit;
  for (genvar b = 0; b < BANKS; b++) begin : gBank
    logic [HIST_DEPTH-1:0] hVal;
    logic [BLK_W-1:0]      hBlk [HIST_DEPTH];
    logic [ROW_W-1:0]      hRow [HIST_DEPTH];
    logic                  push;
    assign push = st.histPush && (reqBank == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hVal <= '0;
        for (int i = 0; i < HIST_DEPTH; i++) begin
          hBlk[i] <= '0;
          hRow[i] <= '0;
        end
      end else if (push) begin
        for (int i = HIST_DEPTH - 1; i > 0; i--) begin
          hVal[i] <= hVal[i-1];
          hBlk[i] <= hBlk[i-1];
          hRow[i] <= hRow[i-1];
        end
        hVal[0] <= 1'b1;
        hBlk[0] <= blk;
        hRow[0] <= newRow;
      end
    end

    always_comb begin
      bankHit[b] = 1'b0;
      for (int i = 0; i < HIST_DEPTH; i++)
        if (hVal[i] && hBlk[i] == blk && hRow[i] == newRow) bankHit[b] = 1'b1;
    end
  end

  assign hit      = bankHit[reqBank];
  assign outBank  = reqBank;
  assign outRow   = newRow;
  assign outCol   = st.selEcc ? eccCol : newCol;
  assign outWrite = st.selEcc ? 1'b0 : reqWrite;
endmodule

// File: rtl/ecc_inj_control.sv
module ecc_inj_control
  import ecc_inj_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        divDone,
  input  logic        hit,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        outEcc,
  output injStrobes_t st
);
  injState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    st          = '0;
    inReady     = 1'b0;
    outValid    = 1'b0;
    outEcc      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          st.load   = 1'b1;
          nextState = ST_DIVIDE;
        end
      end
      ST_DIVIDE: if (divDone) nextState = ST_DECIDE;
      ST_DECIDE: begin
        if (hit) nextState = ST_SEND_DATA;
        else begin
          st.histPush = 1'b1;
          nextState   = ST_SEND_ECC;
        end
      end
      ST_SEND_ECC: begin
        outValid  = 1'b1;
        outEcc    = 1'b1;
        st.selEcc = 1'b1;
        if (outReady) nextState = ST_SEND_DATA;
      end
      ST_SEND_DATA: begin
        outValid = 1'b1;
        if (outReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ecc_fetch_injector.sv
module ecc_fetch_injector
  import ecc_inj_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 11,
  parameter int LOG_SHIFT  = 8,
  parameter int DATA_COLS  = 1792,
  parameter int BLOCK_COLS = 512,
  parameter int ECC_STEP   = 32,
  parameter int HIST_DEPTH = 3,
  localparam int BANK_W    = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BANK_W-1:0] inBank,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic              inWrite,
  output logic              outValid,
  input  logic              outReady,
  output logic [BANK_W-1:0] outBank,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic              outWrite,
  output logic              outEcc,
  input  logic              dsRespValid,
  input  logic              dsRespEcc,
  output logic              dsRespReady,
  output logic              upRespValid,
  input  logic              upRespReady
);
  injStrobes_t st;
  logic divDone, hit;

  ecc_inj_control uCtrl (
    .clk, .rstN, .inValid, .divDone, .hit, .outReady,
    .inReady, .outValid, .outEcc, .st
  );

  ecc_inj_datapath #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .LOG_SHIFT(LOG_SHIFT),
    .DATA_COLS(DATA_COLS), .BLOCK_COLS(BLOCK_COLS), .ECC_STEP(ECC_STEP),
    .HIST_DEPTH(HIST_DEPTH)
  ) uData (
    .clk, .rstN, .st, .inBank, .inRow, .inCol, .inWrite,
    .divDone, .hit, .outBank, .outRow, .outCol, .outWrite
  );

  // internal ECC responses are consumed here; the rest pass through
  assign upRespValid = dsRespValid && !dsRespEcc;
  assign dsRespReady = dsRespEcc ? 1'b1 : upRespReady;
endmodule

// File: rtl/ecc_fetch_injector_checker.sv
module ecc_fetch_injector_checker #(
  parameter int COL_W     = 11,
  parameter int DATA_COLS = 1792
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic             outEcc,
  input logic             outWrite,
  input logic [COL_W-1:0] outCol,
  input logic [31:0]      outSig,
  input logic             dsRespValid,
  input logic             dsRespEcc,
  input logic             dsRespReady,
  input logic             upRespValid
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSig) && $stable(outEcc) && $stable(outCol));

  assert_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_ecc_region_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEcc |-> outCol >= COL_W'(DATA_COLS) && !outWrite);

  assert_data_region_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outEcc |-> outCol < COL_W'(DATA_COLS));

  assert_held_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEcc && outReady |=> outValid && !outEcc);

  assert_absorb_R8: assert property (@(posedge clk) disable iff (!rstN)
    dsRespValid && dsRespEcc |-> dsRespReady && !upRespValid);
endmodule

bind ecc_fetch_injector ecc_fetch_injector_checker #(
  .COL_W(COL_W), .DATA_COLS(DATA_COLS)
) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outEcc(outEcc), .outWrite(outWrite), .outCol(outCol),
  .outSig(32'({outBank, outRow, outWrite})),
  .dsRespValid(dsRespValid), .dsRespEcc(dsRespEcc),
  .dsRespReady(dsRespReady), .upRespValid(upRespValid)
);

// File: tb/ecc_fetch_injector_test.sv
`timescale 1ns/1ps
module ecc_fetch_injector_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, inValid, inReady, inWrite, outValid, outReady, outWrite, outEcc;
  logic dsRespValid, dsRespEcc, dsRespReady, upRespValid, upRespReady;
  logic [1:0]  inBank, outBank;
  logic [7:0]  inRow, outRow;
  logic [10:0] inCol, outCol;

  ecc_fetch_injector uut (.*);

  int total = 0, bad = 0, cyc = 0;
  int mV [4][3], mB [4][3], mR [4][3];

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expectTxn(input int ecc, input int bank, input int row, input int col,
                           input int wr, input string req);
    int waited = 0;
    while (!outValid && waited < 300) begin @(negedge clk); waited++; end
    chkEq(req, "tag", int'(outEcc), ecc);
    chkEq(req, "bank", int'(outBank), bank);
    chkEq(req, "row", int'(outRow), row);
    chkEq(req, "col", int'(outCol), col);
    chkEq(req, "write", int'(outWrite), wr);
    @(negedge clk);
    chkEq("R7", "held col", int'(outCol), col);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic doReq(input int bank, input int row, input int col, input int wr,
                       input int expHit, input string hitReq);
    int idx = row * 256 + col;
    int nr = (row + idx / 1792) & 255;
    int nc = idx % 1792;
    int blk = nc / 512;
    int hit = 0;
    for (int i = 0; i < 3; i++)
      if (mV[bank][i] == 1 && mB[bank][i] == blk && mR[bank][i] == nr) hit = 1;
    if (expHit >= 0) chkEq(hitReq, "model hit", hit, expHit);
    if (hit == 0) begin
      for (int i = 2; i > 0; i--) begin
        mV[bank][i] = mV[bank][i-1]; mB[bank][i] = mB[bank][i-1]; mR[bank][i] = mR[bank][i-1];
      end
      mV[bank][0] = 1; mB[bank][0] = blk; mR[bank][0] = nr;
    end
    inValid = 1'b1; inBank = 2'(bank); inRow = 8'(row); inCol = 11'(col); inWrite = wr[0];
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chkEq("R7", "ready low after accept", int'(inReady), 0);
    if (hit == 0) begin
      expectTxn(1, bank, nr, 1792 + blk * 32, 0, "R4");
      chkEq("R5", "ready low after ecc", int'(inReady), 0);
      expectTxn(0, bank, nr, nc, wr, "R5");
    end else begin
      expectTxn(0, bank, nr, nc, wr, "R3");
    end
    chkEq("R7", "ready back", int'(inReady), 1);
  endtask

  initial begin
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 3; i++) begin mV[b][i] = 0; mB[b][i] = 0; mR[b][i] = 0; end
    rstN = 1'b0; inValid = 1'b0; inBank = '0; inRow = '0; inCol = '0; inWrite = 1'b0;
    outReady = 1'b0; dsRespValid = 1'b0; dsRespEcc = 1'b0; upRespReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "inReady", int'(inReady), 1);
    chkEq("R1", "outValid", int'(outValid), 0);
    chkEq("R1", "upRespValid", int'(upRespValid), 0);
    doReq(0, 0, 0, 0, 0, "R1");
    doReq(0, 0, 5, 1, 1, "R3");

    // sweep rows and columns across block and remap boundaries
    for (int row = 0; row <= 200; row += 13) begin
      int cols [10] = '{0, 1, 255, 256, 511, 512, 1023, 1500, 1791, 2047};
      for (int k = 0; k < 10; k++)
        doReq((row / 13) % 4, row, cols[k], k % 2, -1, "R2");
    end

    // eviction order in bank 3, then bank independence
    doReq(3, 240, 0, 0, -1, "R6");
    doReq(3, 241, 0, 0, -1, "R6");
    doReq(3, 242, 0, 1, -1, "R6");
    doReq(3, 240, 0, 0, 1, "R6");
    doReq(3, 243, 0, 0, 0, "R6");
    doReq(3, 240, 0, 0, 0, "R6");
    doReq(2, 240, 0, 0, 0, "R6");
    doReq(3, 240, 0, 1, 1, "R6");

    // response routing
    dsRespValid = 1'b1; dsRespEcc = 1'b1; upRespReady = 1'b0;
    @(negedge clk);
    chkEq("R8", "ecc resp ready", int'(dsRespReady), 1);
    chkEq("R8", "ecc resp hidden", int'(upRespValid), 0);
    dsRespEcc = 1'b0;
    @(negedge clk);
    chkEq("R8", "data resp valid", int'(upRespValid), 1);
    chkEq("R8", "data resp stalled", int'(dsRespReady), 0);
    upRespReady = 1'b1;
    @(negedge clk);
    chkEq("R8", "data resp ready", int'(dsRespReady), 1);
    dsRespValid = 1'b0;
    @(negedge clk);
    chkEq("R8", "no resp", int'(upRespValid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule